// File: doc/BRIEF.md
# Parallel EEPROM Byte-Write Controller

This block turns a stream of bytes into sequential programming cycles on an external byte-wide EEPROM. Each byte taken from a valid/ready input goes to the next location of a 16-bit address space. The block keeps the address counter itself. Before each write, it shifts the address bit by bit into an external shift-register address latch. It then walks the chip-enable, write-enable and output-enable strobes through a fixed sequence. Every strobe edge is followed by a programmable settle time, deliberately generous.

Once the byte is written, the data bus turns around to input. The controller then reads the device in pairs until two back-to-back reads match, which means the internal programming cycle has stopped toggling the status bits. One more read fetches the stored byte, and the controller offers it on a valid/ready output so the host can compare it with what was sent. If the reads never settle within a cycle budget, the controller raises an error flag, produces no output and goes back to accepting bytes.

Top module: `eew_ctrl`

## Requirements
- R1: After synchronous reset, `ee_ce_n`, `ee_we_n` and `ee_oe_n` are high, `ee_dq_oe` is low, `in_ready` is high, `out_valid` and `timeout_err` are low, and the first byte accepted is written at address 0x0000.
- R2: Before each write, the 16-bit address is shifted out on `sa_dat`, most significant bit first (high byte, then low byte). Each bit is valid on a rising edge of `sa_clk`. `sa_clk` stays low while `ee_ce_n` is low.
- R3: Each accepted byte uses the address one above the previous one. A carry out of the low byte increments the high byte, so 0x00FF is followed by 0x0100.
- R4: In a write, `ee_ce_n` falls first, then `ee_we_n` falls (the address is captured). The byte is then driven on `ee_dq_o` with `ee_dq_oe` high, `ee_we_n` rises (the data is captured), and `ee_ce_n` rises last.
- R5: Between any two changes of the strobe set {`ee_ce_n`, `ee_we_n`, `ee_oe_n`}, at least SETTLE_CYC clock cycles pass with the strobes unchanged.
- R6: `ee_dq_oe` is high through the address and write phases and low whenever `ee_oe_n` is low. The bus is never driven during a read.
- R7: Polling reads come in pairs. Each read pulls `ee_ce_n` and `ee_oe_n` low together and then releases them. Pairs repeat until both reads of a pair are equal, and then exactly one more read follows.
- R8: The final read value appears on `out_data` with `out_valid` high. It is held stable until `out_ready`. `in_ready` is low from acceptance of a byte until its read-back is taken, and then returns high.
- R9: If polling has run POLL_LIMIT cycles without a matching pair, `timeout_err` goes high, all strobes are high, no output is produced and `in_ready` returns high. `timeout_err` clears when the next byte is accepted, and that byte takes the following address.
- R10: `out_data` carries the value read from the device, not the byte that was sent, so a stored value that differs from the sent byte shows up at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte to write is present |
| in_data | input | DATA_W | Byte to write |
| in_ready | output | 1 | Controller can accept a byte |
| out_valid | output | 1 | Read-back byte is present |
| out_data | output | DATA_W | Byte read back from the device |
| out_ready | input | 1 | Consumer takes the read-back byte |
| timeout_err | output | 1 | Last write never finished polling |
| sa_dat | output | 1 | Serial address bit to the address latch |
| sa_clk | output | 1 | Shift clock of the address latch |
| ee_ce_n | output | 1 | Device chip enable, active low |
| ee_we_n | output | 1 | Device write enable, active low |
| ee_oe_n | output | 1 | Device output enable, active low |
| ee_dq_o | output | DATA_W | Data driven toward the device |
| ee_dq_oe | output | 1 | Drive enable for the data bus |
| ee_dq_i | input | DATA_W | Data returned from the device |

## Verification
A corrupted address counter or shifter shows up at the very next write, as a wrong address captured when write-enable falls. A broken strobe sequencer either breaks the edge order within a few cycles or stores the wrong byte, and the read-back on the output exposes that. A fault in the poll-compare state shows up once the byte completes, as a read count that differs from the pair rule for the given number of busy reads, or as a timeout flagged where none was due.

// File: rtl/eew_pkg.sv
package eew_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_WE_LO,
    ST_DRIVE,
    ST_WE_HI,
    ST_CE_HI,
    ST_RD_LO,
    ST_RD_HI,
    ST_DECIDE,
    ST_OUT
  } eew_state_t;
endpackage

// File: rtl/eew_addr_ctr.sv
module eew_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);
  localparam int LO_W = ADDR_W / 2;
  localparam int HI_W = ADDR_W - LO_W;

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (inc) begin
      lo_q <= lo_q + 1'b1;
      if (&lo_q) hi_q <= hi_q + 1'b1;
    end
  end

  assign addr = {hi_q, lo_q};
endmodule

// File: rtl/eew_addr_shift.sv
module eew_addr_shift #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  output logic              sdat,
  output logic              sclk,
  output logic              done
);
  localparam int CNT_W = $clog2(ADDR_W + 1);

  logic [ADDR_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic              busy_q;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      sclk   <= 1'b0;
    end else if (start && !busy_q) begin
      sh_q   <= addr;
      left_q <= CNT_W'(ADDR_W);
      busy_q <= 1'b1;
      sclk   <= 1'b0;
    end else if (busy_q) begin
      if (!sclk) begin
        sclk <= 1'b1;
      end else begin
        sclk   <= 1'b0;
        sh_q   <= {sh_q[ADDR_W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign sdat = sh_q[ADDR_W-1];
endmodule

// File: rtl/eew_poll_timer.sv
module eew_poll_timer #(
  parameter int LIMIT = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (en && cnt_q < CNT_W'(LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q >= CNT_W'(LIMIT));
endmodule

// File: rtl/eew_ctrl.sv
module eew_ctrl #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int SETTLE_CYC = 3,
  parameter int POLL_LIMIT = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              timeout_err,
  output logic              sa_dat,
  output logic              sa_clk,
  output logic              ee_ce_n,
  output logic              ee_we_n,
  output logic              ee_oe_n,
  output logic [DATA_W-1:0] ee_dq_o,
  output logic              ee_dq_oe,
  input  logic [DATA_W-1:0] ee_dq_i
);
  import eew_pkg::*;

  localparam int WAIT_W = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [WAIT_W-1:0] SETTLE_V = WAIT_W'(SETTLE_CYC);

  eew_state_t        state;
  logic [WAIT_W-1:0] wait_cnt;
  logic [DATA_W-1:0] wbyte;
  logic [DATA_W-1:0] samp_a;
  logic [DATA_W-1:0] samp_b;
  logic [DATA_W-1:0] rd_last;
  logic              second;
  logic              final_rd;
  logic              sh_start;
  logic              sh_done;
  logic              addr_inc;
  logic [ADDR_W-1:0] addr;
  logic              tout_clear;
  logic              tout_en;
  logic              tout_expired;

  eew_addr_ctr #(.ADDR_W(ADDR_W)) ctr_i (
    .clk (clk),
    .rst (rst),
    .inc (addr_inc),
    .addr(addr)
  );

  eew_addr_shift #(.ADDR_W(ADDR_W)) shf_i (
    .clk  (clk),
    .rst  (rst),
    .start(sh_start),
    .addr (addr),
    .sdat (sa_dat),
    .sclk (sa_clk),
    .done (sh_done)
  );

  assign tout_clear = (state == ST_CE_HI);
  assign tout_en    = !final_rd &&
                      (state == ST_RD_LO || state == ST_RD_HI || state == ST_DECIDE);

  eew_poll_timer #(.LIMIT(POLL_LIMIT)) tmr_i (
    .clk    (clk),
    .rst    (rst),
    .clear  (tout_clear),
    .en     (tout_en),
    .expired(tout_expired)
  );

  always_ff @(posedge clk) begin
    sh_start <= 1'b0;
    addr_inc <= 1'b0;
    if (rst) begin
      state       <= ST_IDLE;
      wait_cnt    <= '0;
      wbyte       <= '0;
      samp_a      <= '0;
      samp_b      <= '0;
      rd_last     <= '0;
      second      <= 1'b0;
      final_rd    <= 1'b0;
      in_ready    <= 1'b1;
      out_valid   <= 1'b0;
      out_data    <= '0;
      timeout_err <= 1'b0;
      ee_ce_n     <= 1'b1;
      ee_we_n     <= 1'b1;
      ee_oe_n     <= 1'b1;
      ee_dq_o     <= '0;
      ee_dq_oe    <= 1'b0;
    end else if (wait_cnt != '0) begin
      wait_cnt <= wait_cnt - 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            wbyte       <= in_data;
            in_ready    <= 1'b0;
            ee_dq_oe    <= 1'b1;
            timeout_err <= 1'b0;
            sh_start    <= 1'b1;
            state       <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (sh_done) begin
            addr_inc <= 1'b1;
            ee_ce_n  <= 1'b0;
            wait_cnt <= SETTLE_V;
            state    <= ST_WE_LO;
          end
        end
        ST_WE_LO: begin
          ee_we_n  <= 1'b0;
          wait_cnt <= SETTLE_V;
          state    <= ST_DRIVE;
        end
        ST_DRIVE: begin
          ee_dq_o  <= wbyte;
          wait_cnt <= SETTLE_V;
          state    <= ST_WE_HI;
        end
        ST_WE_HI: begin
          ee_we_n  <= 1'b1;
          wait_cnt <= SETTLE_V;
          state    <= ST_CE_HI;
        end
        ST_CE_HI: begin
          ee_ce_n  <= 1'b1;
          ee_dq_oe <= 1'b0;
          second   <= 1'b0;
          final_rd <= 1'b0;
          wait_cnt <= SETTLE_V;
          state    <= ST_RD_LO;
        end
        ST_RD_LO: begin
          ee_ce_n  <= 1'b0;
          ee_oe_n  <= 1'b0;
          wait_cnt <= SETTLE_V;
          state    <= ST_RD_HI;
        end
        ST_RD_HI: begin
          if (final_rd)     rd_last <= ee_dq_i;
          else if (!second) samp_a  <= ee_dq_i;
          else              samp_b  <= ee_dq_i;
          ee_ce_n  <= 1'b1;
          ee_oe_n  <= 1'b1;
          wait_cnt <= SETTLE_V;
          state    <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (final_rd) begin
            out_valid <= 1'b1;
            out_data  <= rd_last;
            state     <= ST_OUT;
          end else if (tout_expired) begin
            timeout_err <= 1'b1;
            in_ready    <= 1'b1;
            state       <= ST_IDLE;
          end else if (!second) begin
            second <= 1'b1;
            state  <= ST_RD_LO;
          end else begin
            second <= 1'b0;
            if (samp_a == samp_b) final_rd <= 1'b1;
            state <= ST_RD_LO;
          end
        end
        ST_OUT: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            in_ready  <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eew_ctrl_chk.sv
module eew_ctrl_chk #(
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              timeout_err,
  input logic              sa_clk,
  input logic              ee_ce_n,
  input logic              ee_we_n,
  input logic              ee_oe_n,
  input logic              ee_dq_oe
);
  logic [2:0]  strb_prev;
  logic [31:0] gap;
  logic        strb_chg;

  assign strb_chg = ({ee_ce_n, ee_we_n, ee_oe_n} != strb_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_prev <= 3'b111;
      gap       <= 32'(SETTLE_CYC);
    end else begin
      strb_prev <= {ee_ce_n, ee_we_n, ee_oe_n};
      if (strb_chg)            gap <= '0;
      else if (gap != '1)      gap <= gap + 1'b1;
    end
  end

  p_idle_released_r1: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (ee_ce_n && ee_we_n && ee_oe_n));

  p_no_shift_selected_r2: assert property (@(posedge clk) disable iff (rst)
    !ee_ce_n |-> !sa_clk);

  p_we_under_ce_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ee_we_n) |-> !ee_ce_n);

  p_ce_after_we_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_ce_n) |-> ee_we_n);

  p_driven_at_latch_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_we_n) |-> ee_dq_oe);

  p_settle_gap_r5: assert property (@(posedge clk) disable iff (rst)
    strb_chg |-> (gap >= 32'(SETTLE_CYC)));

  p_no_contention_r6: assert property (@(posedge clk) disable iff (rst)
    !ee_oe_n |-> !ee_dq_oe);

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_in_out_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  p_err_to_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> (in_ready && !out_valid && ee_ce_n && ee_oe_n));
endmodule

bind eew_ctrl eew_ctrl_chk #(.DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .timeout_err(timeout_err),
  .sa_clk     (sa_clk),
  .ee_ce_n    (ee_ce_n),
  .ee_we_n    (ee_we_n),
  .ee_oe_n    (ee_oe_n),
  .ee_dq_oe   (ee_dq_oe)
);

// File: tb/eew_ctrl_tb_top.sv
`timescale 1ns/1ps
module eew_ctrl_tb_top;
  localparam int DW     = 8;
  localparam int AW     = 16;
  localparam int SETTLE = 2;
  localparam int PLIM   = 300;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          in_ready;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_ready;
  logic          timeout_err;
  logic          sa_dat, sa_clk;
  logic          ee_ce_n, ee_we_n, ee_oe_n;
  logic [DW-1:0] ee_dq_o;
  logic          ee_dq_oe;
  logic [DW-1:0] ee_dq_i;

  always #4 clk = ~clk;

  eew_ctrl #(.DATA_W(DW), .ADDR_W(AW), .SETTLE_CYC(SETTLE), .POLL_LIMIT(PLIM)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .timeout_err(timeout_err), .sa_dat(sa_dat), .sa_clk(sa_clk),
    .ee_ce_n(ee_ce_n), .ee_we_n(ee_we_n), .ee_oe_n(ee_oe_n),
    .ee_dq_o(ee_dq_o), .ee_dq_oe(ee_dq_oe), .ee_dq_i(ee_dq_i)
  );

  // ---------------- device model (acts at falling clock edges) ----------------
  logic [DW-1:0] mem [256];
  logic [AW-1:0] sh_cap, cap_addr;
  logic [DW-1:0] wr_data, rd_val;
  logic          p_sclk = 1'b0, p_we = 1'b1, p_oe = 1'b1;
  logic          ce_at_wfall, drv_at_wrise, ce_at_wrise, tog;
  int            busy_cfg, busy_left, rd_cnt;
  bit            stuck, corrupt;

  assign ee_dq_i = rd_val;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    sh_cap = '0; cap_addr = '0; wr_data = '0; rd_val = '0; tog = 1'b0;
    ce_at_wfall = 1'b0; drv_at_wrise = 1'b0; ce_at_wrise = 1'b0;
    busy_cfg = 0; busy_left = 0; rd_cnt = 0; stuck = 0; corrupt = 0;
  end

  always @(negedge clk) begin
    if (sa_clk && !p_sclk) sh_cap = {sh_cap[AW-2:0], sa_dat};
    if (!ee_we_n && p_we) begin
      cap_addr    = sh_cap;
      ce_at_wfall = !ee_ce_n;
    end
    if (ee_we_n && !p_we) begin
      wr_data      = ee_dq_o;
      drv_at_wrise = ee_dq_oe;
      ce_at_wrise  = !ee_ce_n;
      mem[cap_addr[7:0]] = corrupt ? (ee_dq_o ^ 8'h01) : ee_dq_o;
      busy_left = busy_cfg;
    end
    if (!ee_oe_n && p_oe && !ee_ce_n) begin
      rd_cnt++;
      if (stuck || busy_left > 0) begin
        if (busy_left > 0) busy_left--;
        tog    = ~tog;
        rd_val = {~wr_data[7], tog, 6'b0};
      end else begin
        rd_val = mem[cap_addr[7:0]];
      end
    end
    p_sclk = sa_clk; p_we = ee_we_n; p_oe = ee_oe_n;
  end

  // ---------------- bookkeeping ----------------
  int            n_chk = 0, n_fail = 0;
  logic [AW-1:0] exp_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic accept_byte(input logic [DW-1:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    rd_cnt = 0;
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R8", "in_ready after accept", in_ready, 0);
    chk(timeout_err == 1'b0, "R9", "error cleared on accept", timeout_err, 0);
  endtask

  // full write with checks; bsy = busy status reads, exp_out = expected read-back
  task automatic do_write(input logic [DW-1:0] b, input int bsy,
                          input logic [DW-1:0] exp_out, input int hold);
    int guard, pairs;
    bit rdy_ok;
    busy_cfg = bsy;
    accept_byte(b);
    guard = 0; rdy_ok = 1;
    while (!out_valid && guard < 5000) begin
      if (in_ready) rdy_ok = 0;
      @(negedge clk); guard++;
    end
    chk(out_valid == 1'b1, "R8", "read-back presented", out_valid, 1);
    chk(rdy_ok, "R8", "in_ready low while busy", rdy_ok, 1);
    chk(cap_addr == exp_addr, "R3", "address latched at WE fall (R2 serial order)", cap_addr, exp_addr);
    chk(ce_at_wfall && ce_at_wrise, "R4", "CE low around WE edges", {ce_at_wfall, ce_at_wrise}, 2'b11);
    chk(drv_at_wrise && wr_data == b, "R4", "byte driven at WE rise", wr_data, b);
    pairs = (bsy + 1) / 2 + 1;
    chk(rd_cnt == 2 * pairs + 1, "R7", "number of device reads", rd_cnt, 2 * pairs + 1);
    chk(out_data == exp_out, "R10", "read-back value", out_data, exp_out);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(out_valid && out_data == exp_out && !in_ready, "R8", "held under backpressure",
          out_data, exp_out);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R8", "handshake returns to idle", {out_valid, in_ready}, 2'b01);
    exp_addr++;
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ee_ce_n && ee_we_n && ee_oe_n, "R1", "strobes released", {ee_ce_n, ee_we_n, ee_oe_n}, 3'b111);
    chk(!ee_dq_oe, "R1", "bus set to input", ee_dq_oe, 0);
    chk(in_ready && !out_valid && !timeout_err, "R1", "handshake idle",
        {in_ready, out_valid, timeout_err}, 3'b100);
  endtask

  task automatic t_basic();
    // R1: first write lands on 0x0000; R5/R6 are watched by the checker throughout
    do_write(8'h5A, 0, 8'h5A, 0);
    do_write(8'hC3, 3, 8'hC3, 0);
    do_write(8'h17, 4, 8'h17, 0);
    do_write(8'hE9, 1, 8'hE9, 0);
  endtask

  task automatic t_backpressure();
    do_write(8'h3C, 2, 8'h3C, 6);
  endtask

  task automatic t_corrupt();
    corrupt = 1;
    do_write(8'hA5, 2, 8'hA4, 0);
    corrupt = 0;
  endtask

  task automatic t_carry();
    while (exp_addr != 16'h00FF) do_write(8'(exp_addr) | 8'h01, 0, 8'(exp_addr) | 8'h01, 0);
    do_write(8'h81, 0, 8'h81, 0);
    chk(cap_addr == 16'h00FF, "R3", "address before carry", cap_addr, 16'h00FF);
    do_write(8'h42, 1, 8'h42, 0);
    chk(cap_addr == 16'h0100, "R3", "address after carry", cap_addr, 16'h0100);
  endtask

  task automatic t_timeout();
    int guard;
    bit saw_out;
    stuck = 1; busy_cfg = 0;
    accept_byte(8'h66);
    guard = 0; saw_out = 0;
    while (!timeout_err && guard < 4 * PLIM) begin
      if (out_valid) saw_out = 1;
      @(negedge clk); guard++;
    end
    chk(timeout_err == 1'b1, "R9", "timeout flagged", timeout_err, 1);
    chk(!saw_out && !out_valid, "R9", "no output on timeout", saw_out, 0);
    chk(in_ready && ee_ce_n && ee_we_n && ee_oe_n, "R9", "idle after timeout",
        {in_ready, ee_ce_n, ee_we_n, ee_oe_n}, 4'hF);
    chk(cap_addr == exp_addr, "R9", "timed-out byte address", cap_addr, exp_addr);
    exp_addr++;
    stuck = 0;
    do_write(8'h2D, 2, 8'h2D, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_basic();
    t_backpressure();
    t_corrupt();
    t_timeout();
    t_carry();
    finish_run();
  end
endmodule